// File: doc/BRIEF.md
# GPIO Signal Crossbar

This block sits between a set of on-chip peripherals and a bank of GPIO pads and decides, under register control, which signal reaches which pin. Every pad has two 8-bit selectors. The drive selector picks the level on the pad's output line. The enable selector picks the state of its output-enable line. Every peripheral input has an 8-bit selector that picks the pad feeding it. In each selector, codes 0 and 1 are fixed levels, and a code of 2 or more picks an entry of a source vector, with code 2 picking entry 0.

Software programs the selectors through a plain 32-bit register port. Each word holds four 8-bit selector lanes, and a per-byte strobe allows one lane to be rewritten without touching the other three. The pad inputs pass through a two-flop synchronizer. The synchronized levels feed the peripheral inputs and can also be read back, one bit per pad. The byte address is split into a bank field in bits 11:8 and a word field in bits 7:2. Bank 0 holds the drive selectors, bank 1 the enable selectors, bank 2 the input selectors and bank 3 the pad levels. Read data follows the address combinationally.

Top module: `gpio_xbar`

## Requirements
- R1: The drive selector of pad p sits in bank 0, word p/4, bits 8*(p%4)+7 to 8*(p%4). A write that sets all four byte strobes stores the value, and a read of the same address returns it.
- R2: Drive code 0 puts 0 on pad_out[p] and code 1 puts 1. Code k≥2 passes periph_out[k-2] through. A code whose index lies beyond the periph_out vector gives 0.
- R3: The enable selector of pad p sits in bank 1 at the same word and lane as in R1. Code 0 sets pad_oe[p] to 1 and code 1 sets it to 0. Code k≥2 passes periph_oe[k-2] through, and an index beyond that vector gives 0.
- R4: The input selector of peripheral input s sits in bank 2, word s/4, bits 8*(s%4)+7 to 8*(s%4). Code 0 drives periph_in[s] to 0 and code 1 drives it to 1. Code k≥2 takes the synchronized level of pad k-2, and a code whose pad does not exist gives 0.
- R5: A read of bank 3, word w returns the synchronized level of pad 32*w+b in bit b. Bits for pads that do not exist read as 0.
- R6: On a write, only the lanes whose reg_strb bit is set change. Strobe bit b covers bits 8*b+7 to 8*b.
- R7: After reset, every drive code is 0 and every enable code is 1. Every input code is 0. As a result pad_out, pad_oe and periph_in are all 0, and enable words read 0x01010101.
- R8: A change on pad_in reaches periph_in and the level readback after exactly two rising clock edges, and not after one.
- R9: Writes to bank 3, to banks 4 to 15, to words past the end of a bank, and to lanes past the last selector change nothing. Reads of such places return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, qualified by reg_valid |
| reg_addr | input | 12 | Byte address: bank in 11:8, word in 7:2 |
| reg_wdata | input | 32 | Write data |
| reg_strb | input | 4 | Per-byte write enables |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pad_in | input | NPADS | Raw pad input levels, asynchronous |
| pad_out | output | NPADS | Pad output levels |
| pad_oe | output | NPADS | Pad output enables, 1 = driving |
| periph_out | input | NSRC | Peripheral signals offered to the pad drivers |
| periph_oe | input | NSRC | Peripheral signals offered to the pad enables |
| periph_in | output | NSIG_IN | Routed inputs delivered to the peripherals |

## Verification
The assertions take several things as given. rst_n is low for at least one rising edge before use. NPADS and NSRC each leave room for their codes in an 8-bit lane (count plus 2 no greater than 256). The synchronizer's two-cycle relation is only checked once two edges have passed since reset. The stimulus changes inputs only between clock edges, and it holds a new pad pattern for at least two edges before any routed or read-back value is compared. It uses codes both inside and past the end of each source vector.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int LANE_W         = 8;
  localparam int LANES_PER_WORD = 4;
  localparam int DATA_W         = LANE_W * LANES_PER_WORD;
  localparam int REG_AW         = 12;
  localparam int WORD_W         = 6;
  localparam int BANK_LSB       = 8;
  localparam int BANK_W         = REG_AW - BANK_LSB;
  localparam int LVL_BITS       = 32;

  localparam logic [BANK_W-1:0] BANK_OUT = 4'h0;
  localparam logic [BANK_W-1:0] BANK_OEN = 4'h1;
  localparam logic [BANK_W-1:0] BANK_IN  = 4'h2;
  localparam logic [BANK_W-1:0] BANK_LVL = 4'h3;

  typedef enum logic [1:0] {SRC_CONST0, SRC_CONST1, SRC_SIGNAL} src_kind_e;

  function automatic logic [WORD_W-1:0] lane_word(int unsigned slot);
    return WORD_W'(slot / LANES_PER_WORD);
  endfunction

  function automatic int unsigned lane_pos(int unsigned slot);
    return slot % LANES_PER_WORD;
  endfunction

  function automatic int unsigned lane_shift(int unsigned slot);
    return LANE_W * (slot % LANES_PER_WORD);
  endfunction

  function automatic logic [WORD_W-1:0] lvl_word(int unsigned pad);
    return WORD_W'(pad / LVL_BITS);
  endfunction

  function automatic int unsigned lvl_bit(int unsigned pad);
    return pad % LVL_BITS;
  endfunction

  function automatic src_kind_e code_kind(logic [LANE_W-1:0] code);
    if (code == '0) return SRC_CONST0;
    if (code == LANE_W'(1)) return SRC_CONST1;
    return SRC_SIGNAL;
  endfunction

  function automatic logic [LANE_W-1:0] sig_code(int unsigned idx);
    return LANE_W'(idx + 2);
  endfunction
endpackage

// File: rtl/xbar_lane_bank.sv
module xbar_lane_bank
  import xbar_pkg::*;
#(
  parameter int              NLANES     = 4,
  parameter logic [LANE_W-1:0] RESET_CODE = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [WORD_W-1:0]             wr_word,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [LANES_PER_WORD-1:0]     wr_strb,
  input  logic [WORD_W-1:0]             rd_word,
  output logic [DATA_W-1:0]             rd_data,
  output logic [NLANES-1:0][LANE_W-1:0] lanes
);
  logic [NLANES-1:0] lane_we;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    localparam int SH  = lane_shift(i);
    localparam int POS = lane_pos(i);

    assign lane_we[i] = wr_en && (wr_word == lane_word(i)) && wr_strb[POS];

    always_ff @(posedge clk) begin
      if (!rst_n)          lanes[i] <= RESET_CODE;
      else if (lane_we[i]) lanes[i] <= wr_data[SH +: LANE_W];
    end

    // R6: a lane without its write strobe keeps its code
    p_lane_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_we[i] |=> $stable(lanes[i]));
    // R1: a strobed lane takes the matching byte of the write data
    p_lane_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lane_we[i] |=> lanes[i] == $past(wr_data[SH +: LANE_W]));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NLANES; i++)
      if (rd_word == lane_word(i)) rd_data[lane_shift(i) +: LANE_W] = lanes[i];
  end
endmodule

// File: rtl/xbar_route.sv
module xbar_route
  import xbar_pkg::*;
#(
  parameter int   NOUT = 4,
  parameter int   NSRC = 4,
  parameter logic C0   = 1'b0,
  parameter logic C1   = 1'b1
) (
  input  logic [NOUT-1:0][LANE_W-1:0] codes,
  input  logic [NSRC-1:0]             src,
  output logic [NOUT-1:0]             dout
);
  always_comb begin
    for (int o = 0; o < NOUT; o++) begin
      dout[o] = 1'b0;
      case (code_kind(codes[o]))
        SRC_CONST0: dout[o] = C0;
        SRC_CONST1: dout[o] = C1;
        default: begin
          for (int s = 0; s < NSRC; s++)
            if (codes[o] == sig_code(s)) dout[o] = src[s];
        end
      endcase
    end
  end
endmodule

// File: rtl/xbar_sync.sv
module xbar_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [1:0]   warm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R8: the synchronized value equals the pad value two edges earlier
  p_sync_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_xbar.sv
module gpio_xbar
  import xbar_pkg::*;
#(
  parameter int NPADS   = 40,
  parameter int NSIG_IN = 6,
  parameter int NSRC    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_valid,
  input  logic               reg_write,
  input  logic [11:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic [3:0]         reg_strb,
  output logic [31:0]        reg_rdata,
  input  logic [NPADS-1:0]   pad_in,
  output logic [NPADS-1:0]   pad_out,
  output logic [NPADS-1:0]   pad_oe,
  input  logic [NSRC-1:0]    periph_out,
  input  logic [NSRC-1:0]    periph_oe,
  output logic [NSIG_IN-1:0] periph_in
);
  localparam logic [LANE_W-1:0] OUT_RST = 8'h00;
  localparam logic [LANE_W-1:0] OEN_RST = 8'h01;
  localparam logic [LANE_W-1:0] IN_RST  = 8'h00;

  logic [BANK_W-1:0] bank;
  logic [WORD_W-1:0] word;
  logic              unused_addr_lsb;
  logic              wr_any, wr_out, wr_oen, wr_in;

  assign bank            = reg_addr[REG_AW-1:BANK_LSB];
  assign word            = reg_addr[BANK_LSB-1:2];
  assign unused_addr_lsb = ^reg_addr[1:0];
  assign wr_any          = reg_valid && reg_write;
  assign wr_out          = wr_any && (bank == BANK_OUT);
  assign wr_oen          = wr_any && (bank == BANK_OEN);
  assign wr_in           = wr_any && (bank == BANK_IN);

  logic [NPADS-1:0][LANE_W-1:0]   out_codes;
  logic [NPADS-1:0][LANE_W-1:0]   oen_codes;
  logic [NSIG_IN-1:0][LANE_W-1:0] in_codes;
  logic [DATA_W-1:0]              out_rd, oen_rd, in_rd, lvl_rd;
  logic [NPADS-1:0]               pad_sync;

  xbar_lane_bank #(.NLANES(NPADS), .RESET_CODE(OUT_RST)) u_out_bank (
    .clk, .rst_n, .wr_en(wr_out), .wr_word(word), .wr_data(reg_wdata),
    .wr_strb(reg_strb), .rd_word(word), .rd_data(out_rd), .lanes(out_codes));

  xbar_lane_bank #(.NLANES(NPADS), .RESET_CODE(OEN_RST)) u_oen_bank (
    .clk, .rst_n, .wr_en(wr_oen), .wr_word(word), .wr_data(reg_wdata),
    .wr_strb(reg_strb), .rd_word(word), .rd_data(oen_rd), .lanes(oen_codes));

  xbar_lane_bank #(.NLANES(NSIG_IN), .RESET_CODE(IN_RST)) u_in_bank (
    .clk, .rst_n, .wr_en(wr_in), .wr_word(word), .wr_data(reg_wdata),
    .wr_strb(reg_strb), .rd_word(word), .rd_data(in_rd), .lanes(in_codes));

  xbar_sync #(.W(NPADS)) u_sync (.clk, .rst_n, .d(pad_in), .q(pad_sync));

  xbar_route #(.NOUT(NPADS), .NSRC(NSRC), .C0(1'b0), .C1(1'b1)) u_out_route (
    .codes(out_codes), .src(periph_out), .dout(pad_out));

  xbar_route #(.NOUT(NPADS), .NSRC(NSRC), .C0(1'b1), .C1(1'b0)) u_oe_route (
    .codes(oen_codes), .src(periph_oe), .dout(pad_oe));

  xbar_route #(.NOUT(NSIG_IN), .NSRC(NPADS), .C0(1'b0), .C1(1'b1)) u_in_route (
    .codes(in_codes), .src(pad_sync), .dout(periph_in));

  always_comb begin
    lvl_rd = '0;
    for (int p = 0; p < NPADS; p++)
      if (word == lvl_word(p)) lvl_rd[lvl_bit(p)] = pad_sync[p];
  end

  always_comb begin
    case (bank)
      BANK_OUT: reg_rdata = out_rd;
      BANK_OEN: reg_rdata = oen_rd;
      BANK_IN:  reg_rdata = in_rd;
      BANK_LVL: reg_rdata = lvl_rd;
      default:  reg_rdata = '0;
    endcase
  end

  for (genvar p = 0; p < NPADS; p++) begin : g_pad_chk
    // R3: enable code 1 releases the pad, code 0 drives it
    p_oe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (oen_codes[p] == 8'h01) |-> !pad_oe[p]);
    p_oe_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (oen_codes[p] == 8'h00) |-> pad_oe[p]);
    // R2: drive code 1 holds the pad high
    p_out_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_codes[p] == 8'h01) |-> pad_out[p]);
  end

  for (genvar s = 0; s < NSIG_IN; s++) begin : g_in_chk
    // R4: input code 0 holds the peripheral input low
    p_in_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_codes[s] == 8'h00) |-> !periph_in[s]);
  end

  // R7: the first cycle out of reset leaves every pad released and low
  p_rst_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && periph_in == '0));

  // R9: a write aimed at the level bank leaves every selector alone
  p_lvl_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bank == BANK_LVL) |=>
      ($stable(out_codes) && $stable(oen_codes) && $stable(in_codes)));
endmodule

// File: tb/sim_gpio_xbar.sv
module sim_gpio_xbar;
  localparam int NP = 40;
  localparam int NI = 6;
  localparam int NS = 8;

  localparam int K_RD = 0, K_OUT = 1, K_OE = 2, K_IN = 3;

  typedef struct {
    int          kind;
    int          idx;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_valid = 1'b0, reg_write = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [3:0]    reg_strb = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [NS-1:0] periph_out = '0, periph_oe = '0;
  logic [NI-1:0] periph_in;

  item_t q[$];
  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;

  always #5 clk = ~clk;

  gpio_xbar #(.NPADS(NP), .NSIG_IN(NI), .NSRC(NS)) u0 (
    .clk, .rst_n, .reg_valid, .reg_write, .reg_addr, .reg_wdata, .reg_strb,
    .reg_rdata, .pad_in, .pad_out, .pad_oe, .periph_out, .periph_oe, .periph_in);

  // monitor: pops expectations pushed this cycle and compares them
  always begin
    @(negedge clk);
    #3;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        K_RD:    act = reg_rdata;
        K_OUT:   act = {31'b0, pad_out[it.idx]};
        K_OE:    act = {31'b0, pad_oe[it.idx]};
        default: act = {31'b0, periph_in[it.idx]};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                 it.req, it.kind, it.idx, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
    tick();
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d; reg_strb = s;
    tick();
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic push(input int k, input int i, input logic [31:0] e, input string r);
    item_t it;
    it.kind = k; it.idx = i; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic exp_rd(input logic [11:0] a, input logic [31:0] e, input string r);
    tick();
    reg_addr = a;
    push(K_RD, 0, e, r);
  endtask

  task automatic exp_bit(input int k, input int i, input logic e, input string r);
    tick();
    push(k, i, {31'b0, e}, r);
  endtask

  task automatic set_pads(input logic [NP-1:0] v);
    tick();
    pad_in = v;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    tick();
    rst_n = 1'b1;

    // R7: reset state
    exp_rd(12'h000, 32'h0000_0000, "R7");
    exp_rd(12'h100, 32'h0101_0101, "R7");
    exp_rd(12'h124, 32'h0101_0101, "R7");
    exp_rd(12'h200, 32'h0000_0000, "R7");
    exp_bit(K_OE, 0, 1'b0, "R7");
    exp_bit(K_OUT, 39, 1'b0, "R7");
    exp_bit(K_IN, 0, 1'b0, "R7");

    // R1 R2: drive selectors for pads 4..7
    wr(12'h004, 32'h0504_0100, 4'hF);
    exp_rd(12'h004, 32'h0504_0100, "R1");
    tick(); periph_out = 8'h04;
    exp_bit(K_OUT, 4, 1'b0, "R2");
    exp_bit(K_OUT, 5, 1'b1, "R2");
    exp_bit(K_OUT, 6, 1'b1, "R2");
    exp_bit(K_OUT, 7, 1'b0, "R2");
    tick(); periph_out = 8'h08;
    exp_bit(K_OUT, 6, 1'b0, "R2");
    exp_bit(K_OUT, 7, 1'b1, "R2");
    // R2: code 10 past the vector gives 0, code 9 picks the last entry
    wr(12'h008, 32'h0000_090A, 4'h3);
    tick(); periph_out = 8'hFF;
    exp_bit(K_OUT, 8, 1'b0, "R2");
    exp_bit(K_OUT, 9, 1'b1, "R2");
    exp_bit(K_OUT, 4, 1'b0, "R2");

    // R6: single-lane writes
    wr(12'h004, 32'hFFFF_FF01, 4'h1);
    exp_rd(12'h004, 32'h0504_0101, "R6");
    exp_bit(K_OUT, 4, 1'b1, "R6");
    wr(12'h004, 32'h0200_0000, 4'h8);
    exp_rd(12'h004, 32'h0204_0101, "R6");
    exp_bit(K_OUT, 7, 1'b1, "R6");

    // R3: enable selectors
    wr(12'h104, 32'h0902_0100, 4'hF);
    exp_rd(12'h104, 32'h0902_0100, "R3");
    tick(); periph_oe = 8'h81;
    exp_bit(K_OE, 4, 1'b1, "R3");
    exp_bit(K_OE, 5, 1'b0, "R3");
    exp_bit(K_OE, 6, 1'b1, "R3");
    exp_bit(K_OE, 7, 1'b1, "R3");
    exp_bit(K_OE, 0, 1'b0, "R3");
    tick(); periph_oe = 8'h00;
    exp_bit(K_OE, 6, 1'b0, "R3");
    exp_bit(K_OE, 7, 1'b0, "R3");
    wr(12'h108, 32'h0000_000A, 4'h1);
    tick(); periph_oe = 8'hFF;
    exp_bit(K_OE, 8, 1'b0, "R3");
    exp_rd(12'h108, 32'h0101_010A, "R3");

    // R4: input routing
    wr(12'h200, 32'h2A29_0201, 4'hF);
    wr(12'h204, 32'h0000_0300, 4'h3);
    exp_rd(12'h200, 32'h2A29_0201, "R4");
    exp_rd(12'h204, 32'h0000_0300, "R4");
    set_pads((40'd1 << 39) | 40'd1);
    tick(); tick();
    exp_bit(K_IN, 0, 1'b1, "R4");
    exp_bit(K_IN, 1, 1'b1, "R4");
    exp_bit(K_IN, 2, 1'b1, "R4");
    exp_bit(K_IN, 3, 1'b0, "R4");
    exp_bit(K_IN, 4, 1'b0, "R4");
    exp_bit(K_IN, 5, 1'b0, "R4");
    set_pads((40'd1 << 39) | 40'd3);
    tick(); tick();
    exp_bit(K_IN, 5, 1'b1, "R4");

    // R8: two-edge latency on the routed input and on the readback
    set_pads((40'd1 << 39) | 40'd2);
    exp_bit(K_IN, 1, 1'b1, "R8");
    exp_bit(K_IN, 1, 1'b0, "R8");
    set_pads((40'd1 << 39) | 40'd6);
    exp_rd(12'h300, 32'h0000_0002, "R8");
    exp_rd(12'h300, 32'h0000_0006, "R8");

    // R5: level readback across two words
    set_pads((40'd1 << 33) | (40'd1 << 3));
    tick(); tick();
    exp_rd(12'h300, 32'h0000_0008, "R5");
    exp_rd(12'h304, 32'h0000_0002, "R5");
    exp_rd(12'h308, 32'h0000_0000, "R5");

    // R9: ignored writes and empty reads
    wr(12'h300, 32'hFFFF_FFFF, 4'hF);
    exp_rd(12'h300, 32'h0000_0008, "R9");
    exp_rd(12'h000, 32'h0000_0000, "R9");
    wr(12'h400, 32'hFFFF_FFFF, 4'hF);
    exp_rd(12'h400, 32'h0000_0000, "R9");
    exp_rd(12'h000, 32'h0000_0000, "R9");
    exp_bit(K_OUT, 0, 1'b0, "R9");
    exp_rd(12'h100, 32'h0101_0101, "R9");
    wr(12'h028, 32'h0101_0101, 4'hF);
    exp_rd(12'h028, 32'h0000_0000, "R9");
    exp_rd(12'h024, 32'h0000_0000, "R9");
    wr(12'h204, 32'hFFFF_0302, 4'hF);
    exp_rd(12'h204, 32'h0000_0302, "R9");

    tick(); tick();
    done = 1'b1;
    summary();
  end
endmodule